// File: doc/BRIEF.md
# Legacy Processor Bus Slave Front End

This block lets local synchronous logic act as a slave on an older 8-bit microprocessor bus. It runs on a fast local sampling clock. From that clock it watches the processor's bus clock, its read/not-write line, a 16-bit address and an 8-bit data bus. A fixed address window is set by a base and a mask. A bus cycle that falls inside the window is served: a write hands the captured byte and address to local logic, and a read places a local byte on the data bus.

The bus data is driven through a separate output-enable, so pads and level shifting stay outside the block. Two configuration inputs position the drive window in sampling-clock ticks. One sets how long after the bus clock rises the byte appears. The other sets how long after the bus clock falls the bus is released. One build can then be tuned to hosts whose bus timing differs slightly. The latched cycle address is presented to local logic so that it can look up the read byte.

Top module: `legacy_bus_slave`

## Requirements
- R1: While `rst_i` is high, at the next sampling edge `bus_oe_o` and `wr_stb_o` go low and any cycle in progress is dropped. A bus-clock fall after reset that had no rise after reset produces no strobe and no drive.
- R2: Take a write cycle (`bus_rnw_i`=0) whose address, held from before the bus clock rises, hits the window. `wr_stb_o` is then high for exactly one sampling cycle, after the 3rd sampling edge that follows the bus clock's fall. At that point `wr_addr_o` holds the address and `wr_data_o` holds the data bus value present at the fall.
- R3: A cycle that misses the window produces no write strobe, and neither does a read cycle. A hit is defined as (address & WIN_MASK) == WIN_BASE, with defaults 16'hF000 and 16'hC000, so the window is C000..CFFF.
- R4: In a read cycle that hits the window, `bus_oe_o` rises after the (4+`cfg_on_dly_i`)-th sampling edge that follows the bus clock's rise.
- R5: After a driven read, `bus_oe_o` falls after the (4+`cfg_off_dly_i`)-th sampling edge that follows the bus clock's fall.
- R6: `bus_oe_o` stays low for write cycles and for read cycles that miss the window, and it is never high together with `wr_stb_o`.
- R7: While `bus_oe_o` is high, `bus_data_o` equals `rd_data_i` as registered one sampling cycle earlier.
- R8: If the bus clock falls before the on-delay has expired, the bus is not driven in that cycle.
- R9: If the bus clock rises again while the release delay is still running, `bus_oe_o` drops after the 3rd sampling edge following that rise. The new cycle is then served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Processor bus clock, asynchronous |
| bus_rnw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr_i | input | 16 | Processor address bus |
| bus_data_i | input | 8 | Data bus as seen at the pins |
| cfg_on_dly_i | input | 8 | Ticks from the bus clock rise to the start of drive |
| cfg_off_dly_i | input | 8 | Ticks from the bus clock fall to the release |
| rd_data_i | input | 8 | Byte from local logic for reads |
| cyc_addr_o | output | 16 | Address latched for the current cycle |
| bus_data_o | output | 8 | Byte to drive onto the data bus |
| bus_oe_o | output | 1 | Data bus output-enable |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 16 | Address of the captured write |
| wr_data_o | output | 8 | Captured write byte |

## Verification
The hardest situation to reach is a new rising edge of the bus clock that arrives while the release counter is still running from the previous read. The bench reaches it by setting a release delay longer than the low phase it drives. It then checks that the enable drops exactly at the rise detection and comes back after the new on-delay. The opposite case is a bus clock that falls before the on-delay has elapsed. The bench reaches it with a short high phase and a long on-delay. Reset is also applied in the middle of a driven read and in the middle of a write. This shows that no stale strobe or drive survives it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   typedef enum logic [1:0] {
      DRV_IDLE = 2'd0,
      DRV_WAIT = 2'd1,
      DRV_ON   = 2'd2,
      DRV_HOLD = 2'd3
   } drv_state_e;

   typedef struct packed {
      logic active;
      logic rnw;
      logic hit;
   } cyc_info_t;
endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) chain_q[0] <= async_i;
         end else begin : g_next
            always_ff @(posedge clk_i) chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lbs_phase.sv
module lbs_phase
   import lbs_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          DW       = 8,
   parameter logic [AW-1:0] WIN_BASE = '0,
   parameter logic [AW-1:0] WIN_MASK = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          bclk_s_i,
   input  logic          rnw_s_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          rise_o,
   output logic          fall_o,
   output logic          rd_start_o,
   output cyc_info_t     cyc_o,
   output logic [AW-1:0] cyc_addr_o,
   output logic          wr_stb_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o
);
   logic bclk_d;
   logic hit_now;

   assign rise_o     = bclk_s_i & ~bclk_d;
   assign fall_o     = ~bclk_s_i & bclk_d;
   assign hit_now    = ((addr_i & WIN_MASK) == WIN_BASE);
   assign rd_start_o = rise_o & rnw_s_i & hit_now;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         bclk_d     <= bclk_s_i;
         cyc_o      <= '0;
         cyc_addr_o <= '0;
         wr_stb_o   <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
      end else begin
         bclk_d   <= bclk_s_i;
         wr_stb_o <= 1'b0;
         if (rise_o) begin
            cyc_o.active <= 1'b1;
            cyc_o.rnw    <= rnw_s_i;
            cyc_o.hit    <= hit_now;
            cyc_addr_o   <= addr_i;
         end else if (fall_o) begin
            cyc_o.active <= 1'b0;
            if (cyc_o.active && !cyc_o.rnw && cyc_o.hit) begin
               wr_stb_o  <= 1'b1;
               wr_addr_o <= cyc_addr_o;
               wr_data_o <= data_i;
            end
         end
      end
   end

   assert_stb_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_stb_o |=> !wr_stb_o);
   assert_stb_write_only_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_start_o |=> !wr_stb_o);
endmodule

// File: rtl/lbs_drive.sv
module lbs_drive
   import lbs_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DW      = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          rd_start_i,
   input  logic [CW-1:0] on_dly_i,
   input  logic [CW-1:0] off_dly_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          oe_o,
   output logic [DW-1:0] dout_o
);
   drv_state_e    st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q  <= DRV_IDLE;
         cnt_q <= '0;
         oe_o  <= 1'b0;
      end else if (rise_i) begin
         oe_o  <= 1'b0;
         cnt_q <= '0;
         st_q  <= rd_start_i ? DRV_WAIT : DRV_IDLE;
      end else begin
         unique case (st_q)
            DRV_WAIT: begin
               if (fall_i) begin
                  st_q <= DRV_IDLE;
               end else if (cnt_q == on_dly_i) begin
                  oe_o <= 1'b1;
                  st_q <= DRV_ON;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            DRV_ON: begin
               if (fall_i) begin
                  cnt_q <= '0;
                  st_q  <= DRV_HOLD;
               end
            end
            DRV_HOLD: begin
               if (cnt_q == off_dly_i) begin
                  oe_o <= 1'b0;
                  st_q <= DRV_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk_i) begin
            if (rst_i) dout_o <= '0;
            else       dout_o <= rd_data_i;
         end
      end else begin : g_comb_out
         assign dout_o = rd_data_i;
      end
   endgenerate

   assert_rise_drop_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_i |=> !oe_o);
   assert_fall_no_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (fall_i && !oe_o) |=> !oe_o);
endmodule

// File: rtl/legacy_bus_slave.sv
module legacy_bus_slave
   import lbs_pkg::*;
#(
   parameter int              AW          = 16,
   parameter int              DW          = 8,
   parameter int              CW          = 8,
   parameter int              SYNC_STAGES = 2,
   parameter bit              OUT_REG     = 1'b1,
   parameter logic [AW-1:0]   WIN_BASE    = 16'hC000,
   parameter logic [AW-1:0]   WIN_MASK    = 16'hF000
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          bus_clk_i,
   input  logic          bus_rnw_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [DW-1:0] bus_data_i,
   input  logic [CW-1:0] cfg_on_dly_i,
   input  logic [CW-1:0] cfg_off_dly_i,
   input  logic [DW-1:0] rd_data_i,
   output logic [AW-1:0] cyc_addr_o,
   output logic [DW-1:0] bus_data_o,
   output logic          bus_oe_o,
   output logic          wr_stb_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o
);
   localparam int SYNC_W = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((WIN_BASE & ~WIN_MASK) != '0) begin : g_bad_win
         $error("WIN_BASE has bits outside WIN_MASK");
      end
      if (CW < 1 || DW < 1 || AW < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   logic [SYNC_W-1:0] ctl_s;
   logic              rise, fall, rd_start;
   cyc_info_t         cyc;

   lbs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .async_i ({bus_rnw_i, bus_clk_i}),
      .sync_o  (ctl_s)
   );

   lbs_phase #(.AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_phase (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .bclk_s_i   (ctl_s[0]),
      .rnw_s_i    (ctl_s[1]),
      .addr_i     (bus_addr_i),
      .data_i     (bus_data_i),
      .rise_o     (rise),
      .fall_o     (fall),
      .rd_start_o (rd_start),
      .cyc_o      (cyc),
      .cyc_addr_o (cyc_addr_o),
      .wr_stb_o   (wr_stb_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o)
   );

   lbs_drive #(.CW(CW), .DW(DW), .OUT_REG(OUT_REG)) u_drive (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rise_i     (rise),
      .fall_i     (fall),
      .rd_start_i (rd_start),
      .on_dly_i   (cfg_on_dly_i),
      .off_dly_i  (cfg_off_dly_i),
      .rd_data_i  (rd_data_i),
      .oe_o       (bus_oe_o),
      .dout_o     (bus_data_o)
   );

   assert_reset_clear_R1: assert property (@(posedge clk_i)
      rst_i |=> (!bus_oe_o && !wr_stb_o));
   assert_oe_read_hit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      bus_oe_o |-> (cyc.rnw && cyc.hit));
   assert_oe_wr_excl_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !(bus_oe_o && wr_stb_o));
endmodule

// File: tb/legacy_bus_slave_bench.sv
module legacy_bus_slave_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bclk = 1'b0;
   logic        rnw = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  bdata = '0;
   logic [7:0]  on_dly = '0;
   logic [7:0]  off_dly = '0;
   logic [7:0]  rdata = 8'h5A;
   logic [15:0] cyc_addr, wr_addr;
   logic [7:0]  dout, wr_data;
   logic        oe, wr_stb;
   int          vec = 0;
   int          bad = 0;

   always #4 clk = ~clk;

   legacy_bus_slave u_legacy_bus_slave (
      .clk_i(clk), .rst_i(rst), .bus_clk_i(bclk), .bus_rnw_i(rnw),
      .bus_addr_i(addr), .bus_data_i(bdata), .cfg_on_dly_i(on_dly),
      .cfg_off_dly_i(off_dly), .rd_data_i(rdata), .cyc_addr_o(cyc_addr),
      .bus_data_o(dout), .bus_oe_o(oe), .wr_stb_o(wr_stb),
      .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // One read cycle; oe_before is the enable expected before the rise is seen
   task automatic read_cycle(input logic [15:0] a, input int d, input int h,
                             input int hi, input int lo, input bit hit,
                             input bit oe_before);
      bit drove;
      drove = hit && (hi >= 4 + d);
      on_dly = 8'(d); off_dly = 8'(h); addr = a; rnw = 1'b1;
      bclk = 1'b1;
      for (int j = 1; j <= hi; j++) begin
         @(negedge clk);
         if (j < 3) check("R9 enable before rise seen", oe, oe_before);
         else check(hit ? "R4 drive start" : "R6 miss no drive", oe,
                    hit && (j >= 4 + d));
         if (oe) check("R7 drive byte", dout, rdata);
         check("R3 no strobe in read", wr_stb, 0);
      end
      bclk = 1'b0;
      for (int j = 1; j <= lo; j++) begin
         @(negedge clk);
         check(drove ? "R5 release" : "R8 no late drive", oe, drove && (j < 4 + h));
         if (oe) check("R7 drive byte", dout, rdata);
      end
   endtask

   task automatic write_cycle(input logic [15:0] a, input logic [7:0] v, input bit hit);
      addr = a; rnw = 1'b0; bdata = 8'h00;
      bclk = 1'b1;
      repeat (6) @(negedge clk);
      bdata = v;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      for (int j = 1; j <= 10; j++) begin
         @(negedge clk);
         check(hit ? "R2 strobe timing" : "R3 miss no strobe", wr_stb, hit && (j == 3));
         check("R6 no drive in write", oe, 0);
         if (j == 3 && hit) begin
            check("R2 write address", wr_addr, a);
            check("R2 write data", wr_data, v);
         end
      end
      rnw = 1'b1;
   endtask

   task automatic test_reset;
      // mid-read reset
      on_dly = 0; off_dly = 2; addr = 16'hC010; rnw = 1'b1; bclk = 1'b1;
      repeat (8) @(negedge clk);
      check("R1 precondition drive", oe, 1);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check("R1 reset clears enable", oe, 0);
      check("R1 reset clears strobe", wr_stb, 0);
      bclk = 1'b0;
      for (int j = 1; j <= 12; j++) begin
         @(negedge clk);
         check("R1 dropped read", oe, 0);
      end
      // mid-write reset
      addr = 16'hC020; rnw = 1'b0; bdata = 8'h77; bclk = 1'b1;
      repeat (8) @(negedge clk);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      bclk = 1'b0;
      for (int j = 1; j <= 10; j++) begin
         @(negedge clk);
         check("R1 dropped write", wr_stb, 0);
      end
      rnw = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 reset enable", oe, 0);
      check("R1 reset strobe", wr_stb, 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      // R4/R5 several delay settings, R7 data
      rdata = 8'hA5; read_cycle(16'hC000, 0, 0, 20, 20, 1, 0);
      rdata = 8'h3C; read_cycle(16'hCFFF, 3, 5, 20, 20, 1, 0);
      rdata = 8'hF0; read_cycle(16'hC123, 10, 2, 20, 20, 1, 0);
      // R6 misses at the window edges
      read_cycle(16'hD000, 0, 0, 20, 20, 0, 0);
      read_cycle(16'hBFFF, 0, 0, 20, 20, 0, 0);
      // R2/R3 writes
      write_cycle(16'hC444, 8'h9E, 1);
      write_cycle(16'hCFFF, 8'h01, 1);
      write_cycle(16'h1234, 8'h55, 0);
      // R8 fall before on-delay expires
      read_cycle(16'hC008, 5, 0, 4, 20, 1, 0);
      // R9 re-rise while release counter still running
      rdata = 8'h66;
      read_cycle(16'hC100, 1, 30, 12, 6, 1, 0);
      read_cycle(16'hC200, 2, 0, 20, 20, 1, 1);
      test_reset();
      read_cycle(16'hC300, 1, 1, 20, 20, 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule